// File: doc/BRIEF.md
# Control-Word Sequencer for a Programmable Serial Controller

This block decides where each control write from the CPU lands while a serial controller is being set up. A control write carries the select input high; a data write carries it low and goes to the serial datapath, which this block does not own. After any reset the first control word configures the line (the mode byte). In synchronous operation one or two sync characters follow it, and every control word after that updates the command byte. The sequence can be restarted from software by a command word with its reset bit set.

The mode byte sets how many control writes come before the command stage. Its two lowest bits equal to `00` select synchronous operation. Any other value selects asynchronous operation, which skips both sync characters. In synchronous operation, bit 7 of the mode byte set to 1 asks for a single sync character, and 0 asks for two. In a command word, bit 6 is the software reset bit. It raises a one-clock internal reset pulse, clears the command byte and returns the sequencer to the mode stage. The mode and sync bytes keep their values until they are rewritten.

Top module: `ctlword_seq`

## Requirements
- R1: After external reset (`rst` high at a clock edge) the mode, both sync and command outputs read 0x00, `irst_pulse` is low, and the next control write is taken as the mode byte.
- R2: A write with `wr_en`=1 and `cd_sel`=1 in the mode stage loads `wr_data` into `mode_byte`. The value is visible after that clock edge.
- R3: If the mode byte just loaded has bits [1:0] not equal to `00` (asynchronous), the next control write loads `cmd_byte` and leaves both sync bytes untouched.
- R4: If the mode byte has bits [1:0]=`00` and bit 7=1, the next control write loads `sync1_byte`, and the control write after it loads `cmd_byte`.
- R5: If the mode byte has bits [1:0]=`00` and bit 7=0, the next two control writes load `sync1_byte` and then `sync2_byte`, and the third loads `cmd_byte`.
- R6: Once the command stage is reached, every control write with bit 6 clear loads `cmd_byte`, including control writes placed between data writes.
- R7: A cycle with `wr_en`=0, or with `wr_en`=1 and `cd_sel`=0 (data write), changes no output register and does not advance the sequence.
- R8: A control write in the command stage with bit 6 set drives `irst_pulse` high for exactly the one clock after that edge. The same edge clears `cmd_byte` to 0x00, and the next control write is taken as the mode byte.
- R9: The internal reset of R8 leaves `mode_byte`, `sync1_byte` and `sync2_byte` at their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | External synchronous reset, active high |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| cd_sel | input | 1 | 1 = control word, 0 = data |
| wr_data | input | 8 | Write data byte |
| mode_byte | output | 8 | Latched mode byte |
| sync1_byte | output | 8 | Latched first sync character |
| sync2_byte | output | 8 | Latched second sync character |
| cmd_byte | output | 8 | Latched command byte |
| irst_pulse | output | 1 | One-clock internal reset pulse |

## Verification
Every output register updates at the same rising edge that captures the write. The internal reset pulse is also registered, so it is high in the cycle right after that edge and low one cycle later. The bench drives each write on a falling edge and removes the strobe on the next falling edge. It reads the outputs at that second falling edge, so each result is checked half a clock after the edge that produced it. The pulse width is checked again one clock later. The bench steps through all 256 mode bytes. In each pass it places data writes and strobe-free cycles between the control writes, and it works out from the mode bits alone which register each byte should have reached.

// File: rtl/ctlword_seq_pkg.sv
package ctlword_seq_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_REGS  = 4;
    localparam int REG_MODE  = 0;
    localparam int REG_SYNC1 = 1;
    localparam int REG_SYNC2 = 2;
    localparam int REG_CMD   = 3;

    typedef enum logic [1:0] {
        ST_MODE  = 2'd0,
        ST_SYNC1 = 2'd1,
        ST_SYNC2 = 2'd2,
        ST_CMD   = 2'd3
    } seq_stage_e;

    typedef struct packed {
        seq_stage_e stage;
        logic       irst;
    } fsm_state_t;

endpackage

// File: rtl/ctlword_mode_decode.sv
module ctlword_mode_decode #(
    parameter int DATA_W     = 8,
    parameter int SEL_W      = 2,
    parameter int SINGLE_BIT = 7
) (
    input  logic [DATA_W-1:0] mode_in,
    output logic [1:0]        sync_count
);
    localparam logic [SEL_W-1:0] SYNC_CODE = '0;

    always_comb begin
        if (mode_in[SEL_W-1:0] != SYNC_CODE) begin
            sync_count = 2'd0;
        end else if (mode_in[SINGLE_BIT]) begin
            sync_count = 2'd1;
        end else begin
            sync_count = 2'd2;
        end
    end
endmodule

// File: rtl/ctlword_stage_fsm.sv
module ctlword_stage_fsm
    import ctlword_seq_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NREG     = 4,
    parameter int IRST_BIT = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        new_sync_count,
    input  logic [1:0]        cur_sync_count,
    output logic [NREG-1:0]   load_en,
    output logic              clr_cmd,
    output logic              irst_q
);
    fsm_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        state_d.irst = 1'b0;
        load_en = '0;
        clr_cmd = 1'b0;
        if (ctl_wr) begin
            unique case (state_q.stage)
                ST_MODE: begin
                    load_en[REG_MODE] = 1'b1;
                    state_d.stage = (new_sync_count == 2'd0) ? ST_CMD : ST_SYNC1;
                end
                ST_SYNC1: begin
                    load_en[REG_SYNC1] = 1'b1;
                    state_d.stage = (cur_sync_count == 2'd2) ? ST_SYNC2 : ST_CMD;
                end
                ST_SYNC2: begin
                    load_en[REG_SYNC2] = 1'b1;
                    state_d.stage = ST_CMD;
                end
                ST_CMD: begin
                    if (wr_data[IRST_BIT]) begin
                        clr_cmd       = 1'b1;
                        state_d.irst  = 1'b1;
                        state_d.stage = ST_MODE;
                    end else begin
                        load_en[REG_CMD] = 1'b1;
                    end
                end
                default: state_d.stage = ST_MODE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '{stage: ST_MODE, irst: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign irst_q = state_q.irst;

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        irst_q |=> !irst_q);

    a_r8_back_to_mode: assert property (@(posedge clk) disable iff (rst)
        irst_q |-> state_q.stage == ST_MODE);

    a_r3_async_skips_sync: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && state_q.stage == ST_MODE && wr_data[1:0] != 2'b00)
        |=> state_q.stage == ST_CMD);

    a_r7_stage_hold: assert property (@(posedge clk) disable iff (rst)
        !ctl_wr |=> $stable(state_q.stage));
endmodule

// File: rtl/ctlword_regbank.sv
module ctlword_regbank
    import ctlword_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NREG   = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NREG-1:0]              load_en,
    input  logic                         clr_cmd,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [NREG-1:0][DATA_W-1:0]  regs_q
);
    logic [NREG-1:0][DATA_W-1:0] regs_d;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_comb begin
            regs_d[g] = regs_q[g];
            if (load_en[g]) begin
                regs_d[g] = wr_data;
            end
            if (g == REG_CMD && clr_cmd) begin
                regs_d[g] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    a_r2_mode_loaded: assert property (@(posedge clk) disable iff (rst)
        load_en[REG_MODE] |=> regs_q[REG_MODE] == $past(wr_data));

    a_r6_cmd_loaded: assert property (@(posedge clk) disable iff (rst)
        load_en[REG_CMD] |=> regs_q[REG_CMD] == $past(wr_data));

    a_r8_cmd_cleared: assert property (@(posedge clk) disable iff (rst)
        clr_cmd |=> regs_q[REG_CMD] == '0);

    a_r9_cfg_kept: assert property (@(posedge clk) disable iff (rst)
        clr_cmd |=> $stable(regs_q[REG_MODE]) && $stable(regs_q[REG_SYNC1])
                    && $stable(regs_q[REG_SYNC2]));
endmodule

// File: rtl/ctlword_seq.sv
module ctlword_seq
    import ctlword_seq_pkg::*;
#(
    parameter int DATA_W     = BYTE_W,
    parameter int SEL_W      = 2,
    parameter int SINGLE_BIT = 7,
    parameter int IRST_BIT   = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              cd_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] mode_byte,
    output logic [DATA_W-1:0] sync1_byte,
    output logic [DATA_W-1:0] sync2_byte,
    output logic [DATA_W-1:0] cmd_byte,
    output logic              irst_pulse
);
    logic                              ctl_wr;
    logic [1:0]                        new_cnt, cur_cnt;
    logic [NUM_REGS-1:0]               load_en;
    logic                              clr_cmd;
    logic [NUM_REGS-1:0][DATA_W-1:0]   regs_q;

    assign ctl_wr = wr_en & cd_sel;

    ctlword_mode_decode #(.DATA_W(DATA_W), .SEL_W(SEL_W), .SINGLE_BIT(SINGLE_BIT))
        i_dec_new (.mode_in(wr_data), .sync_count(new_cnt));

    ctlword_mode_decode #(.DATA_W(DATA_W), .SEL_W(SEL_W), .SINGLE_BIT(SINGLE_BIT))
        i_dec_cur (.mode_in(regs_q[REG_MODE]), .sync_count(cur_cnt));

    ctlword_stage_fsm #(.DATA_W(DATA_W), .NREG(NUM_REGS), .IRST_BIT(IRST_BIT)) i_fsm (
        .clk            (clk),
        .rst            (rst),
        .ctl_wr         (ctl_wr),
        .wr_data        (wr_data),
        .new_sync_count (new_cnt),
        .cur_sync_count (cur_cnt),
        .load_en        (load_en),
        .clr_cmd        (clr_cmd),
        .irst_q         (irst_pulse)
    );

    ctlword_regbank #(.DATA_W(DATA_W), .NREG(NUM_REGS)) i_regs (
        .clk     (clk),
        .rst     (rst),
        .load_en (load_en),
        .clr_cmd (clr_cmd),
        .wr_data (wr_data),
        .regs_q  (regs_q)
    );

    assign mode_byte  = regs_q[REG_MODE];
    assign sync1_byte = regs_q[REG_SYNC1];
    assign sync2_byte = regs_q[REG_SYNC2];
    assign cmd_byte   = regs_q[REG_CMD];

    a_r7_no_ctl_no_change: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && cd_sel) |=> $stable(mode_byte) && $stable(sync1_byte)
                              && $stable(sync2_byte) && $stable(cmd_byte));

    a_r8_pulse_cmd_zero: assert property (@(posedge clk) disable iff (rst)
        irst_pulse |-> cmd_byte == '0);
endmodule

// File: tb/test_ctlword_seq.sv
module test_ctlword_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       cd_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] mode_byte, sync1_byte, sync2_byte, cmd_byte;
    logic       irst_pulse;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ctlword_seq i_ctlword_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .cd_sel(cd_sel), .wr_data(wr_data),
        .mode_byte(mode_byte), .sync1_byte(sync1_byte), .sync2_byte(sync2_byte),
        .cmd_byte(cmd_byte), .irst_pulse(irst_pulse)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic put(input logic we, input logic cd, input logic [7:0] d);
        @(negedge clk);
        wr_en = we; cd_sel = cd; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; cd_sel = 1'b0; wr_data = 8'h00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk("R1 mode", mode_byte, 8'h00);
        chk("R1 sync1", sync1_byte, 8'h00);
        chk("R1 sync2", sync2_byte, 8'h00);
        chk("R1 cmd", cmd_byte, 8'h00);
        chk("R1 irst", {7'd0, irst_pulse}, 8'h00);

        for (int m = 0; m < 256; m++) begin
            logic [7:0] mb, v0, v1, v2;
            int nsync;
            string tag;
            mb = 8'(m);
            v0 = (mb ^ 8'h3C) & 8'hBF;
            v1 = (mb + 8'h11) & 8'hBF;
            v2 = (~mb) & 8'hBF;
            nsync = (mb[1:0] != 2'b00) ? 0 : (mb[7] ? 1 : 2);
            tag = (nsync == 0) ? "R3" : ((nsync == 1) ? "R4" : "R5");

            do_reset();
            put(1'b1, 1'b1, mb);
            chk("R2 mode load", mode_byte, mb);
            put(1'b1, 1'b0, 8'hE7);          // data write
            put(1'b0, 1'b1, 8'hC3);          // no strobe
            chk("R7 mode hold", mode_byte, mb);
            chk("R7 sync1 hold", sync1_byte, 8'h00);
            chk("R7 cmd hold", cmd_byte, 8'h00);

            put(1'b1, 1'b1, v0);
            chk({tag, " cmd after 1st"}, cmd_byte, (nsync == 0) ? v0 : 8'h00);
            put(1'b1, 1'b0, 8'hFF);          // data between control writes
            chk("R7 R6 data no load", cmd_byte, (nsync == 0) ? v0 : 8'h00);
            put(1'b1, 1'b1, v1);
            put(1'b1, 1'b1, v2);
            chk({tag, " sync1"}, sync1_byte, (nsync >= 1) ? v0 : 8'h00);
            chk({tag, " sync2"}, sync2_byte, (nsync == 2) ? v1 : 8'h00);
            chk({tag, " R6 cmd"}, cmd_byte, v2);
            chk("R8 no spurious pulse", {7'd0, irst_pulse}, 8'h00);

            put(1'b1, 1'b1, v2 | 8'h40);
            chk("R8 pulse high", {7'd0, irst_pulse}, 8'h01);
            chk("R8 cmd cleared", cmd_byte, 8'h00);
            chk("R9 mode kept", mode_byte, mb);
            chk("R9 sync1 kept", sync1_byte, (nsync >= 1) ? v0 : 8'h00);
            chk("R9 sync2 kept", sync2_byte, (nsync == 2) ? v1 : 8'h00);
            @(negedge clk);
            chk("R8 pulse one clock", {7'd0, irst_pulse}, 8'h00);
            put(1'b1, 1'b1, 8'h5A);
            chk("R8 rearm mode", mode_byte, 8'h5A);
            chk("R8 cmd untouched", cmd_byte, 8'h00);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule